// File: doc/BRIEF.md
# Triple Compare Watchdog Timer

This peripheral holds three watchdog channels behind one 32-bit register bus. Each channel owns a counter that advances on a single-cycle reference tick. Software can load that counter with any value. Each channel also has a reset threshold and a small control word. While a channel's reset enable is on and its counter has reached or passed its threshold, the channel holds a reset request high.

Channel 0 drives a recovery-mode reset request. Channels 1 and 2 drive normal machine reset requests. Channel 0 also has a second, lower threshold that raises a warning interrupt ahead of the reset. That interrupt is latched in a status bit of channel 0's control word, and software clears it by writing 1 to that bit. Software keeps the system alive by writing the counter back to a low value before the threshold is reached. A threshold of zero with reset enable set forces an immediate reset.

Top module: `trio_wdt`

## Requirements
- R1: After reset, every counter and control word reads 0, every reset and warning threshold reads all ones at the counter width, and all three reset requests and the interrupt are low.
- R2: Register offsets: channel n (n = 0, 1, 2) has its counter at n*0x10, its reset threshold at n*0x10+0x4 and its control word at n*0x10+0xC. The warning threshold of channel 0 is at 0x08. Reads return the register value zero-extended to 32 bits.
- R3: A counter that is not being written advances by one on each cycle with `tick` high, wraps from all ones to 0, and holds its value otherwise.
- R4: A write to a counter loads the low counter-width bits of the write data. If a tick arrives in the same cycle, the written value wins.
- R5: Control word bits: bit 0 is interrupt enable, bit 1 is interrupt status, bit 2 is reset enable. Bits 0 and 2 are stored for every channel. Bit 1 reads as 0 on channels 1 and 2.
- R6: A channel's reset request is high whenever its reset enable is 1 and its counter is greater than or equal to its reset threshold. Channel 0 drives `recoveryRstReq`, channel 1 drives `normalRstReq[0]` and channel 2 drives `normalRstReq[1]`. The request follows register contents with no extra delay.
- R7: On a clock edge where channel 0's interrupt enable is 1 and its counter is greater than or equal to its warning threshold, the status bit is set. `barkIrq` equals the status bit ANDed with interrupt enable.
- R8: Writing 1 to bit 1 of channel 0's control word clears the status bit, unless the warning condition holds at that edge, in which case the bit stays set. Writing 0 to bit 1 leaves it unchanged.
- R9: With reset enable set, writing 0 to a channel's reset threshold raises its reset request in the next cycle, whatever the counter holds.
- R10: Reads of unmapped offsets return 0 and writes to them change no register. Unmapped offsets are any address with nonzero low two bits, 0x18, 0x28, and any address of 0x30 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Reference tick, one cycle wide |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| recoveryRstReq | output | 1 | Recovery-mode reset request from channel 0 |
| normalRstReq | output | 2 | Normal reset requests from channels 1 and 2 |
| barkIrq | output | 1 | Level interrupt from channel 0's warning threshold |

## Verification
The bench builds the block with an 8-bit counter and an 8-bit address. With an 8-bit counter, wraparound is a few ticks away, and the all-ones reset thresholds are small enough to check directly. The 8-bit address decodes the full register map along with every unmapped slot above it. A behavioural model of all three channels runs beside the design and is compared on every clock for the read data, the three reset requests and the interrupt. Directed sequences then push the warning status through set, a refused clear and an accepted clear.

// File: rtl/trio_wdt_pkg.sv
package trio_wdt_pkg;

  localparam int NUM_CH     = 3;
  localparam int BUS_W      = 32;
  localparam int CTRL_W     = 3;
  localparam int BIT_IRQ_EN = 0;
  localparam int BIT_IRQ_ST = 1;
  localparam int BIT_RST_EN = 2;
  localparam int BARK_CH    = 0;

  localparam logic [3:0] OFS_CNT  = 4'h0;
  localparam logic [3:0] OFS_BITE = 4'h4;
  localparam logic [3:0] OFS_BARK = 4'h8;
  localparam logic [3:0] OFS_CTRL = 4'hC;

  typedef struct packed {
    logic [NUM_CH-1:0] ldCnt;
    logic [NUM_CH-1:0] ldBite;
    logic [NUM_CH-1:0] ldCtrl;
    logic              ldBark;
  } wdtStrobe_t;

endpackage

// File: rtl/trio_wdt_ctrl.sv
module trio_wdt_ctrl
  import trio_wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             busWrEn,
  input  logic [ADDR_W-1:0]                busAddr,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     cntQ,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     biteQ,
  input  logic [CNT_W-1:0]                 barkQ,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]    ctrlQ,
  output wdtStrobe_t                       strobe,
  output logic [BUS_W-1:0]                 busRdData
);

  localparam int SEL_W = ADDR_W - 4;

  logic [SEL_W-1:0] chSel;
  logic [3:0]       regOfs;
  logic [NUM_CH-1:0] chHit;

  assign chSel  = busAddr[ADDR_W-1:4];
  assign regOfs = busAddr[3:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gDecode
    assign chHit[g]         = (chSel == SEL_W'(g));
    assign strobe.ldCnt[g]  = busWrEn && chHit[g] && (regOfs == OFS_CNT);
    assign strobe.ldBite[g] = busWrEn && chHit[g] && (regOfs == OFS_BITE);
    assign strobe.ldCtrl[g] = busWrEn && chHit[g] && (regOfs == OFS_CTRL);
  end
  assign strobe.ldBark = busWrEn && chHit[BARK_CH] && (regOfs == OFS_BARK);

  always_comb begin
    busRdData = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (chHit[c]) begin
        unique case (regOfs)
          OFS_CNT:  busRdData = BUS_W'(cntQ[c]);
          OFS_BITE: busRdData = BUS_W'(biteQ[c]);
          OFS_BARK: busRdData = (c == BARK_CH) ? BUS_W'(barkQ) : '0;
          OFS_CTRL: busRdData = BUS_W'(ctrlQ[c]);
          default:  busRdData = '0;
        endcase
      end
    end
  end

  // R10: no register is touched without a bus write
  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |-> (strobe == '0));
  // R10: at most one register is loaded per write
  a_r10_single_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

endmodule

// File: rtl/trio_wdt_datapath.sv
module trio_wdt_datapath
  import trio_wdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  wdtStrobe_t                    strobe,
  input  logic [BUS_W-1:0]              wrData,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cntQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]  biteQ,
  output logic [CNT_W-1:0]              barkQ,
  output logic [NUM_CH-1:0][CTRL_W-1:0] ctrlQ,
  output logic [NUM_CH-1:0]             rstReq,
  output logic                          irq
);

  logic [CNT_W-1:0]  loadVal;
  logic [NUM_CH-1:0] irqEnQ;
  logic [NUM_CH-1:0] rstEnQ;
  logic              statQ;
  logic              barkHit;
  logic              clrReq;

  assign loadVal = wrData[CNT_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ[g] <= '0;
      end else if (strobe.ldCnt[g]) begin
        cntQ[g] <= loadVal;
      end else if (tick) begin
        cntQ[g] <= cntQ[g] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        biteQ[g] <= '1;
      end else if (strobe.ldBite[g]) begin
        biteQ[g] <= loadVal;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqEnQ[g] <= 1'b0;
        rstEnQ[g] <= 1'b0;
      end else if (strobe.ldCtrl[g]) begin
        irqEnQ[g] <= wrData[BIT_IRQ_EN];
        rstEnQ[g] <= wrData[BIT_RST_EN];
      end
    end

    assign rstReq[g] = rstEnQ[g] && (cntQ[g] >= biteQ[g]);

    if (g == BARK_CH) begin : gStat
      assign ctrlQ[g] = {rstEnQ[g], statQ, irqEnQ[g]};
    end else begin : gNoStat
      assign ctrlQ[g] = {rstEnQ[g], 1'b0, irqEnQ[g]};
    end

    // R3: counter advances by one on a tick when not written
    a_r3_tick_advance: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.ldCnt[g] && tick) |=> (cntQ[g] == CNT_W'($past(cntQ[g]) + 1'b1)));
    // R3: counter holds without tick or write
    a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.ldCnt[g] && !tick) |=> $stable(cntQ[g]));
    // R4: a load wins over a simultaneous tick
    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rstN)
      strobe.ldCnt[g] |=> (cntQ[g] == $past(loadVal)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      barkQ <= '1;
    end else if (strobe.ldBark) begin
      barkQ <= loadVal;
    end
  end

  assign barkHit = irqEnQ[BARK_CH] && (cntQ[BARK_CH] >= barkQ);
  assign clrReq  = strobe.ldCtrl[BARK_CH] && wrData[BIT_IRQ_ST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ <= 1'b0;
    end else begin
      statQ <= barkHit || (statQ && !clrReq);
    end
  end

  assign irq = statQ && irqEnQ[BARK_CH];

  // R7: warning condition latches the status bit
  a_r7_bark_sets: assert property (@(posedge clk) disable iff (!rstN)
    barkHit |=> statQ);
  // R8: a clear with the condition gone drops the status bit
  a_r8_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (statQ && !barkHit && clrReq) |=> !statQ);
  // R8: without a clear the status bit is sticky
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statQ && !clrReq) |=> statQ);

endmodule

// File: rtl/trio_wdt.sv
module trio_wdt
  import trio_wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              recoveryRstReq,
  output logic [1:0]        normalRstReq,
  output logic              barkIrq
);

  wdtStrobe_t                    strobe;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntQ;
  logic [NUM_CH-1:0][CNT_W-1:0]  biteQ;
  logic [CNT_W-1:0]              barkQ;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrlQ;
  logic [NUM_CH-1:0]             rstReq;

  trio_wdt_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .cntQ      (cntQ),
    .biteQ     (biteQ),
    .barkQ     (barkQ),
    .ctrlQ     (ctrlQ),
    .strobe    (strobe),
    .busRdData (busRdData)
  );

  trio_wdt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .tick   (tick),
    .strobe (strobe),
    .wrData (busWrData),
    .cntQ   (cntQ),
    .biteQ  (biteQ),
    .barkQ  (barkQ),
    .ctrlQ  (ctrlQ),
    .rstReq (rstReq),
    .irq    (barkIrq)
  );

  assign recoveryRstReq = rstReq[0];
  assign normalRstReq   = rstReq[2:1];

endmodule

// File: tb/sim_trio_wdt.sv
module sim_trio_wdt;

  localparam int AW   = 8;
  localparam int CW   = 8;
  localparam int MASK = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          tick = 1'b0;
  logic          busWrEn = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic          recoveryRstReq;
  logic [1:0]    normalRstReq;
  logic          barkIrq;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;

  always #2.5 clk = ~clk;

  trio_wdt #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .recoveryRstReq(recoveryRstReq), .normalRstReq(normalRstReq),
    .barkIrq(barkIrq)
  );

  // behavioural reference model
  int unsigned mCnt[3];
  int unsigned mBite[3];
  int unsigned mBark;
  bit          mIe[3];
  bit          mRe[3];
  bit          mSt;
  bit          mHit;
  bit          mClr;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) begin
        mCnt[c] = 0; mBite[c] = MASK; mIe[c] = 0; mRe[c] = 0;
      end
      mBark = MASK; mSt = 0;
    end else begin
      mHit = mIe[0] && (mCnt[0] >= mBark);
      mClr = busWrEn && (busAddr == 8'h0C) && busWrData[1];
      for (int c = 0; c < 3; c++) begin
        if (busWrEn && busAddr == 8'(c * 16)) mCnt[c] = busWrData & MASK;
        else if (tick) mCnt[c] = (mCnt[c] + 1) & MASK;
        if (busWrEn && busAddr == 8'(c * 16 + 4)) mBite[c] = busWrData & MASK;
        if (busWrEn && busAddr == 8'(c * 16 + 12)) begin
          mIe[c] = busWrData[0];
          mRe[c] = busWrData[2];
        end
      end
      if (busWrEn && busAddr == 8'h08) mBark = busWrData & MASK;
      mSt = mHit || (mSt && !mClr);
    end
  end

  function automatic logic [31:0] mRead(logic [AW-1:0] a);
    for (int c = 0; c < 3; c++) begin
      if (a == 8'(c * 16))      return mCnt[c];
      if (a == 8'(c * 16 + 4))  return mBite[c];
      if (a == 8'(c * 16 + 12)) return {29'd0, mRe[c], (c == 0) ? mSt : 1'b0, mIe[c]};
    end
    if (a == 8'h08) return mBark;
    return 32'd0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model (R2, R6, R7)
  always @(negedge clk) begin
    if (rstN) begin
      chk("R2 read data", busRdData, mRead(busAddr));
      chk("R6 recovery request", {31'd0, recoveryRstReq},
          {31'd0, mRe[0] && (mCnt[0] >= mBite[0])});
      chk("R6 normal request ch1", {31'd0, normalRstReq[0]},
          {31'd0, mRe[1] && (mCnt[1] >= mBite[1])});
      chk("R6 normal request ch2", {31'd0, normalRstReq[1]},
          {31'd0, mRe[2] && (mCnt[2] >= mBite[2])});
      chk("R7 interrupt", {31'd0, barkIrq}, {31'd0, mSt && mIe[0]});
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nFail++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  task automatic cyc(bit we, logic [AW-1:0] a, logic [31:0] d, bit tk);
    @(posedge clk);
    #1;
    busWrEn = we; busAddr = a; busWrData = d; tick = tk;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    cyc(0, a, 0, 0);
    @(negedge clk);
    chk(tag, busRdData, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(8'h00, 0, "R1 counter0");
    rd(8'h04, MASK, "R1 bite0");
    rd(8'h08, MASK, "R1 bark0");
    rd(8'h0C, 0, "R1 ctrl0");
    rd(8'h24, MASK, "R1 bite2");
    chk("R1 outputs", {28'd0, recoveryRstReq, normalRstReq, barkIrq}, 0);

    // R3 increment and wrap
    repeat (5) cyc(0, 8'h00, 0, 1);
    rd(8'h00, 5, "R3 count ticks");
    cyc(1, 8'h10, 32'hFE, 0);
    repeat (3) cyc(0, 8'h00, 0, 1);
    rd(8'h10, 1, "R3 wrap");

    // R4 write wins over tick
    cyc(1, 8'h20, 32'h40, 1);
    rd(8'h20, 32'h40, "R4 write beats tick");

    // R5 control fields
    cyc(1, 8'h1C, 7, 0);
    rd(8'h1C, 5, "R5 ctrl ch1 no status");

    // R6 normal reset from channel 1
    cyc(1, 8'h14, 32'h10, 0);
    cyc(1, 8'h10, 32'h0E, 0);
    cyc(0, 8'h00, 0, 1);
    cyc(0, 8'h00, 0, 1);
    cyc(0, 8'h00, 0, 0);
    @(negedge clk);
    chk("R6 ch1 request at threshold", {31'd0, normalRstReq[0]}, 1);
    cyc(1, 8'h1C, 0, 0);
    rd(8'h1C, 0, "R5 ctrl ch1 cleared");
    chk("R6 ch1 request dropped", {31'd0, normalRstReq[0]}, 0);

    // R9 zero threshold
    cyc(1, 8'h2C, 4, 0);
    cyc(1, 8'h24, 0, 0);
    cyc(0, 8'h00, 0, 0);
    @(negedge clk);
    chk("R9 zero threshold resets", {31'd0, normalRstReq[1]}, 1);

    // R7 / R8 warning status on channel 0
    cyc(1, 8'h08, 32'h20, 0);
    cyc(1, 8'h00, 0, 0);
    cyc(1, 8'h0C, 1, 0);
    cyc(1, 8'h00, 32'h20, 0);
    cyc(0, 8'h00, 0, 0);
    cyc(0, 8'h00, 0, 0);
    @(negedge clk);
    chk("R7 interrupt raised", {31'd0, barkIrq}, 1);
    rd(8'h0C, 3, "R7 status set");
    cyc(1, 8'h0C, 3, 0);
    rd(8'h0C, 3, "R8 clear refused while condition holds");
    cyc(1, 8'h00, 0, 0);
    cyc(1, 8'h0C, 1, 0);
    rd(8'h0C, 3, "R8 write 0 keeps status");
    cyc(1, 8'h0C, 3, 0);
    rd(8'h0C, 1, "R8 clear accepted");
    chk("R7 interrupt cleared", {31'd0, barkIrq}, 0);

    // R6 recovery reset from channel 0
    cyc(1, 8'h04, 5, 0);
    cyc(1, 8'h00, 5, 0);
    cyc(1, 8'h0C, 4, 0);
    cyc(0, 8'h00, 0, 0);
    @(negedge clk);
    chk("R6 recovery request", {31'd0, recoveryRstReq}, 1);

    // R10 unmapped offsets
    cyc(1, 8'h18, 32'hAA, 0);
    cyc(1, 8'h30, 32'hAA, 0);
    cyc(1, 8'h15, 32'h00, 0);
    rd(8'h18, 0, "R10 read 0x18");
    rd(8'h30, 0, "R10 read 0x30");
    rd(8'h28, 0, "R10 read 0x28");
    rd(8'h14, 32'h10, "R10 misaligned write ignored");

    repeat (3) cyc(0, 8'h00, 0, 0);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule